// File: doc/BRIEF.md
# Key-Search Register Slave

This block is the software-facing register file of a brute-force key-search engine. It is an AXI4-Lite slave with a 12-bit byte address and 32-bit data. It holds a 64-bit plaintext, a 64-bit ciphertext and a 56-bit starting key, and drives them onto plain output ports. Two 56-bit inputs from the search controller can be read back through the bus: the progress key and the found key.

Some accesses have side effects toward the search controller, which sits outside this block. Writing one half of the starting key launches a search, and writing the other half halts it. Reading the low half of the progress key asks the controller to hold its value, and reading the high half releases it. The pair of 32-bit reads therefore returns one coherent 56-bit value. Each side effect is a single-cycle pulse, raised in the same cycle as the matching response valid.

The read and write channels are independent and can complete in the same cycle. Every response field comes from a register, so it stays constant while its valid is high.

Top module: `keyhunt_csr`

## Requirements
- R1: After a synchronous active-low reset, these are all low or zero: every ready and response valid, the plaintext, ciphertext and start-key outputs, and the four pulse outputs.
- R2: A read request seen at a rising edge raises `arReady` and `rValid` together for the following cycle. `arReady` lasts exactly one cycle. `rValid` stays high until an edge with `rReady` high. Back-to-back reads complete every two cycles.
- R3: A write is accepted only at an edge where `awValid` and `wValid` are both high. `awReady`, `wReady` and `bValid` then rise together, and the two readies last one cycle.
- R4: While a response valid is high and not yet accepted, its data and response code do not change. New requests on that channel are ignored until the response is accepted.
- R5: Only address bits 11:2 are decoded. Word index = byte address / 4. Words 0–1 hold the plaintext (low word first), words 2–3 the ciphertext, and words 4–5 the start key. Words 6–7 return the progress key and words 8–9 the found key. A read of any of these returns OKAY (2'b00), and bits 31:24 of words 5, 7 and 9 read as zero.
- R6: A read at word index 10 or above returns DECERR (2'b11) with all-zero data.
- R7: A write to words 0–5 returns OKAY and updates only the bytes whose `wStrb` bit is set. Byte 3 of word 5 is never stored.
- R8: A write to words 6–9 returns SLVERR (2'b10). A write at word 10 or above returns DECERR (2'b11). In both cases no register changes.
- R9: An accepted write to byte 0x014 pulses `startPulse`, and one to byte 0x010 pulses `stopPulse`. Each pulse lasts one cycle and coincides with the rise of `bValid`.
- R10: An accepted read of byte 0x018 pulses `freezePulse`, and one of byte 0x01C pulses `unfreezePulse`. Each pulse lasts one cycle and coincides with the rise of `rValid`.
- R11: A read and a write presented together are accepted at the same edge. A read of the word being written returns its contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| arAddr | input | 12 | Read byte address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| awAddr | input | 12 | Write byte address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte enables |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response code |
| rValid | output | 1 | Read response valid |
| rReady | input | 1 | Read response accepted by master |
| bResp | output | 2 | Write response code |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response accepted by master |
| progKey | input | 56 | Progress key from the search controller |
| foundKey | input | 56 | Found key from the search controller |
| plainText | output | 64 | Stored plaintext |
| cipherText | output | 64 | Stored ciphertext |
| startKey | output | 56 | Stored starting key |
| startPulse | output | 1 | Launch-search pulse |
| stopPulse | output | 1 | Halt-search pulse |
| freezePulse | output | 1 | Hold-progress pulse |
| unfreezePulse | output | 1 | Release-progress pulse |

## Verification
A read and a write can be accepted at the same clock edge, and both can target the same register word. The bench raises `arValid`, `awValid` and `wValid` together, with both addresses on plaintext word 0. In the following cycle it expects all three readies and both response valids to be high. The read data must show the value from before the write, and a later read must return the new value. Separately, the bench holds a read response unaccepted and changes the request address, to show that the response is held and the new request is ignored.

// File: rtl/keyhunt_csr_pkg.sv
package keyhunt_csr_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int STRB_W   = DATA_W / 8;
  localparam int LSB      = $clog2(STRB_W);
  localparam int WORD_W   = ADDR_W - LSB;
  localparam int IDX_W    = 4;
  localparam int RW_WORDS = 6;
  localparam int ALL_WORDS = 10;
  localparam int KEY_W    = 56;
  localparam int BLK_W    = 64;
  localparam int KEY_TOP  = KEY_W - DATA_W;

  localparam logic [WORD_W-1:0] RW_LIMIT  = WORD_W'(RW_WORDS);
  localparam logic [WORD_W-1:0] MAP_LIMIT = WORD_W'(ALL_WORDS);

  localparam logic [IDX_W-1:0] IDX_KEY_LO   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_KEY_HI   = 4'd5;
  localparam logic [IDX_W-1:0] IDX_PROG_LO  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_PROG_HI  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_FOUND_LO = 4'd8;
  localparam logic [IDX_W-1:0] IDX_FOUND_HI = 4'd9;
  localparam logic [IDX_W-1:0] IDX_RW_END   = IDX_W'(RW_WORDS);

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {REG_RW, REG_RO, REG_NONE} region_e;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
    logic [STRB_W-1:0] wrStrb;
    logic              rdEn;
    logic [IDX_W-1:0]  rdIdx;
  } csr_strobe_t;

  function automatic region_e regionOf(input logic [WORD_W-1:0] word);
    if (word < RW_LIMIT) return REG_RW;
    else if (word < MAP_LIMIT) return REG_RO;
    else return REG_NONE;
  endfunction
endpackage

// File: rtl/keyhunt_csr_ctrl.sv
module keyhunt_csr_ctrl
  import keyhunt_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [DATA_W-1:0] rdVal,
  output csr_strobe_t       strb
);
  logic    rdAccept, wrAccept;
  region_e rdReg, wrReg;
  logic    unusedAddrBits;

  assign unusedAddrBits = ^{arAddr[LSB-1:0], awAddr[LSB-1:0]};
  assign rdAccept = arValid && !rValid;
  assign wrAccept = awValid && wValid && !bValid;

  always_comb begin
    rdReg       = regionOf(arAddr[ADDR_W-1:LSB]);
    wrReg       = regionOf(awAddr[ADDR_W-1:LSB]);
    strb.wrEn   = wrAccept && (wrReg == REG_RW);
    strb.wrIdx  = awAddr[LSB+IDX_W-1:LSB];
    strb.wrData = wData;
    strb.wrStrb = wStrb;
    strb.rdEn   = rdAccept && (rdReg != REG_NONE);
    strb.rdIdx  = arAddr[LSB+IDX_W-1:LSB];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arReady <= 1'b0;
      rValid  <= 1'b0;
      rData   <= '0;
      rResp   <= RESP_OKAY;
    end else begin
      arReady <= rdAccept;
      rValid  <= rdAccept || (rValid && !rReady);
      if (rdAccept) begin
        rData <= (rdReg == REG_NONE) ? '0 : rdVal;
        rResp <= (rdReg == REG_NONE) ? RESP_DECERR : RESP_OKAY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awReady <= 1'b0;
      wReady  <= 1'b0;
      bValid  <= 1'b0;
      bResp   <= RESP_OKAY;
    end else begin
      awReady <= wrAccept;
      wReady  <= wrAccept;
      bValid  <= wrAccept || (bValid && !bReady);
      if (wrAccept) begin
        case (wrReg)
          REG_RW:  bResp <= RESP_OKAY;
          REG_RO:  bResp <= RESP_SLVERR;
          default: bResp <= RESP_DECERR;
        endcase
      end
    end
  end

  // R2
  ar_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    arReady |=> !arReady);
  // R2
  ar_ready_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    arReady |-> rValid);
  // R3
  aw_w_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    awReady |-> (wReady && bValid));
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData) && $stable(rResp)));
  // R4
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bResp)));
  // R6
  decerr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rResp == RESP_DECERR) |-> (rData == '0));
endmodule

// File: rtl/keyhunt_csr_dp.sv
module keyhunt_csr_dp
  import keyhunt_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strb,
  input  logic [KEY_W-1:0]  progKey,
  input  logic [KEY_W-1:0]  foundKey,
  output logic [DATA_W-1:0] rdVal,
  output logic [BLK_W-1:0]  plainText,
  output logic [BLK_W-1:0]  cipherText,
  output logic [KEY_W-1:0]  startKey,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              freezePulse,
  output logic              unfreezePulse
);
  logic [DATA_W-1:0] rwWord [RW_WORDS];

  for (genvar gw = 0; gw < RW_WORDS; gw++) begin : g_word
    localparam logic [STRB_W-1:0] KEEP_MASK =
      (gw == RW_WORDS - 1) ? {1'b0, {(STRB_W-1){1'b1}}} : {STRB_W{1'b1}};
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordQ <= '0;
      end else if (strb.wrEn && strb.wrIdx == IDX_W'(gw)) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (strb.wrStrb[b] && KEEP_MASK[b]) wordQ[b*8 +: 8] <= strb.wrData[b*8 +: 8];
        end
      end
    end
    assign rwWord[gw] = wordQ;
  end

  always_comb begin
    rdVal = '0;
    if (strb.rdIdx < IDX_RW_END) begin
      rdVal = rwWord[strb.rdIdx[2:0]];
    end else begin
      case (strb.rdIdx)
        IDX_PROG_LO:  rdVal = progKey[DATA_W-1:0];
        IDX_PROG_HI:  rdVal = {{(DATA_W-KEY_TOP){1'b0}}, progKey[KEY_W-1:DATA_W]};
        IDX_FOUND_LO: rdVal = foundKey[DATA_W-1:0];
        IDX_FOUND_HI: rdVal = {{(DATA_W-KEY_TOP){1'b0}}, foundKey[KEY_W-1:DATA_W]};
        default:      rdVal = '0;
      endcase
    end
  end

  assign plainText  = {rwWord[1], rwWord[0]};
  assign cipherText = {rwWord[3], rwWord[2]};
  assign startKey   = {rwWord[5][KEY_TOP-1:0], rwWord[4]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPulse    <= 1'b0;
      stopPulse     <= 1'b0;
      freezePulse   <= 1'b0;
      unfreezePulse <= 1'b0;
    end else begin
      startPulse    <= strb.wrEn && (strb.wrIdx == IDX_KEY_HI);
      stopPulse     <= strb.wrEn && (strb.wrIdx == IDX_KEY_LO);
      freezePulse   <= strb.rdEn && (strb.rdIdx == IDX_PROG_LO);
      unfreezePulse <= strb.rdEn && (strb.rdIdx == IDX_PROG_HI);
    end
  end

  // R9
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !stopPulse);
  // R10
  freeze_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    freezePulse |=> !freezePulse);
  // R10
  freeze_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    freezePulse |-> !unfreezePulse);
endmodule

// File: rtl/keyhunt_csr.sv
module keyhunt_csr
  import keyhunt_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [DATA_W-1:0] wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic              wValid,
  output logic              wReady,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rValid,
  input  logic              rReady,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady,
  input  logic [KEY_W-1:0]  progKey,
  input  logic [KEY_W-1:0]  foundKey,
  output logic [BLK_W-1:0]  plainText,
  output logic [BLK_W-1:0]  cipherText,
  output logic [KEY_W-1:0]  startKey,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              freezePulse,
  output logic              unfreezePulse
);
  csr_strobe_t       strb;
  logic [DATA_W-1:0] rdVal;

  keyhunt_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .rdVal(rdVal), .strb(strb)
  );

  keyhunt_csr_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .progKey(progKey), .foundKey(foundKey), .rdVal(rdVal),
    .plainText(plainText), .cipherText(cipherText), .startKey(startKey),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .freezePulse(freezePulse), .unfreezePulse(unfreezePulse)
  );
endmodule

// File: tb/keyhunt_csr_bench.sv
module keyhunt_csr_bench;
  localparam time CLK_PERIOD = 4ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] arAddr = '0, awAddr = '0;
  logic        arValid = 0, awValid = 0, wValid = 0, rReady = 1, bReady = 1;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  logic        arReady, awReady, wReady, rValid, bValid;
  logic [31:0] rData;
  logic [1:0]  rResp, bResp;
  logic [55:0] progKey = '0, foundKey = '0;
  logic [63:0] plainText, cipherText;
  logic [55:0] startKey;
  logic        startPulse, stopPulse, freezePulse, unfreezePulse;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyhunt_csr u_keyhunt_csr (
    .clk(clk), .rstN(rstN),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .progKey(progKey), .foundKey(foundKey),
    .plainText(plainText), .cipherText(cipherText), .startKey(startKey),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .freezePulse(freezePulse), .unfreezePulse(unfreezePulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                         output logic [1:0] resp, output logic st, output logic sp);
    awAddr = a; wData = d; wStrb = s; awValid = 1; wValid = 1; bReady = 1;
    do tick(); while (!awReady);
    resp = bResp; st = startPulse; sp = stopPulse;
    awValid = 0; wValid = 0;
    tick();
  endtask

  task automatic doRead(input logic [11:0] a, output logic [31:0] d, output logic [1:0] resp,
                        output logic fz, output logic uf);
    arAddr = a; arValid = 1; rReady = 1;
    do tick(); while (!arReady);
    d = rData; resp = rResp; fz = freezePulse; uf = unfreezePulse;
    arValid = 0;
    tick();
  endtask

  task automatic testReset();
    chk("R1 arReady", arReady, 0);  chk("R1 awReady", awReady, 0);
    chk("R1 rValid", rValid, 0);    chk("R1 bValid", bValid, 0);
    chk("R1 plainText", plainText, 0); chk("R1 startKey", startKey, 0);
    chk("R1 pulses", {startPulse, stopPulse, freezePulse, unfreezePulse}, 0);
  endtask

  task automatic testBlocks();
    logic [1:0] r; logic a, b; logic [31:0] d;
    doWrite(12'h000, 32'h11223344, 4'hF, r, a, b); chk("R7 pt0 resp", r, 2'b00);
    doWrite(12'h004, 32'h55667788, 4'hF, r, a, b);
    doWrite(12'h008, 32'hFFFFFFFF, 4'hF, r, a, b);
    doWrite(12'h00C, 32'h9ABCDEF0, 4'hF, r, a, b);
    chk("R7 plainText", plainText, 64'h55667788_11223344);
    doRead(12'h007, d, r, a, b);
    chk("R5 pt1 via unaligned addr", d, 32'h55667788); chk("R5 resp", r, 2'b00);
    doWrite(12'h008, 32'h00AA00BB, 4'b0101, r, a, b);
    chk("R7 partial strobe", cipherText, 64'h9ABCDEF0_FFAAFFBB);
    doRead(12'h008, d, r, a, b); chk("R7 partial readback", d, 32'hFFAAFFBB);
  endtask

  task automatic testKeyRegs();
    logic [1:0] r; logic st, sp; logic [31:0] d;
    doWrite(12'h010, 32'hCAFEBABE, 4'hF, r, st, sp);
    chk("R9 stop on low write", sp, 1); chk("R9 no start on low write", st, 0);
    doWrite(12'h014, 32'hFFEEDDCC, 4'hF, r, st, sp);
    chk("R9 start on high write", st, 1); chk("R9 no stop on high write", sp, 0);
    chk("R9 start is one cycle", startPulse, 0);
    chk("R7 startKey top byte dropped", startKey, 56'hEEDDCC_CAFEBABE);
    doRead(12'h014, d, r, st, sp); chk("R5 key high reads top zero", d, 32'h00EEDDCC);
  endtask

  task automatic testProgress();
    logic [1:0] r; logic fz, uf; logic [31:0] d;
    progKey = 56'hABCDEF_01234567; foundKey = 56'h13579B_2468ACE0;
    doRead(12'h018, d, r, fz, uf);
    chk("R10 freeze on prog low", fz, 1); chk("R10 no unfreeze", uf, 0);
    chk("R5 prog low", d, 32'h01234567);
    doRead(12'h01C, d, r, fz, uf);
    chk("R10 unfreeze on prog high", uf, 1); chk("R10 no freeze", fz, 0);
    chk("R5 prog high", d, 32'h00ABCDEF);
    chk("R10 unfreeze is one cycle", unfreezePulse, 0);
    doRead(12'h020, d, r, fz, uf); chk("R5 found low", d, 32'h2468ACE0);
    doRead(12'h026, d, r, fz, uf); chk("R5 found high", d, 32'h0013579B);
    chk("R5 found resp", r, 2'b00);
  endtask

  task automatic testErrors();
    logic [1:0] r; logic a, b; logic [31:0] d;
    doWrite(12'h018, 32'hDEADBEEF, 4'hF, r, a, b); chk("R8 slverr prog", r, 2'b10);
    doWrite(12'h024, 32'hDEADBEEF, 4'hF, r, a, b); chk("R8 slverr found", r, 2'b10);
    doWrite(12'h040, 32'hDEADBEEF, 4'hF, r, a, b); chk("R8 decerr alias", r, 2'b11);
    doWrite(12'h028, 32'hDEADBEEF, 4'hF, r, a, b); chk("R8 decerr 0x028", r, 2'b11);
    chk("R8 no store on errors", plainText, 64'h55667788_11223344);
    doRead(12'h028, d, r, a, b);
    chk("R6 decerr resp", r, 2'b11); chk("R6 decerr data", d, 0);
    doRead(12'hFFC, d, r, a, b);
    chk("R6 top decerr resp", r, 2'b11); chk("R6 top data", d, 0);
  endtask

  task automatic testHandshake();
    arAddr = 12'h000; arValid = 1; rReady = 0;
    tick();
    chk("R2 arReady after edge", arReady, 1); chk("R2 rValid with arReady", rValid, 1);
    chk("R2 data", rData, 32'h11223344);
    arAddr = 12'h00C;
    tick();
    chk("R2 arReady one cycle", arReady, 0); chk("R4 rValid held", rValid, 1);
    chk("R4 rData held", rData, 32'h11223344);
    tick();
    chk("R4 new request ignored", arReady, 0); chk("R4 rData still held", rData, 32'h11223344);
    rReady = 1;
    tick();
    chk("R2 rValid drops on accept", rValid, 0);
    tick();
    chk("R2 next read after two cycles", arReady, 1); chk("R2 next data", rData, 32'h9ABCDEF0);
    arValid = 0;
    tick();
    awAddr = 12'h004; wData = 32'h0BADF00D; wStrb = 4'hF; awValid = 1; bReady = 0;
    tick(); tick();
    chk("R3 no accept without wValid", {awReady, wReady, bValid}, 0);
    wValid = 1;
    tick();
    chk("R3 readies and bValid together", {awReady, wReady, bValid}, 3'b111);
    awValid = 0; wValid = 0;
    tick();
    chk("R3 readies one cycle", {awReady, wReady}, 0); chk("R4 bValid held", bValid, 1);
    chk("R4 bResp held", bResp, 2'b00);
    bReady = 1;
    tick();
    chk("R4 bValid released", bValid, 0);
    chk("R7 handshake write stored", plainText, 64'h0BADF00D_11223344);
  endtask

  task automatic testSimultaneous();
    logic [1:0] r; logic a, b; logic [31:0] d;
    arAddr = 12'h000; arValid = 1; rReady = 1;
    awAddr = 12'h000; wData = 32'h76543210; wStrb = 4'hF; awValid = 1; wValid = 1; bReady = 1;
    tick();
    chk("R11 both accepted", {arReady, awReady, wReady, rValid, bValid}, 5'b11111);
    chk("R11 read returns old value", rData, 32'h11223344);
    arValid = 0; awValid = 0; wValid = 0;
    tick();
    doRead(12'h000, d, r, a, b); chk("R11 new value after", d, 32'h76543210);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    rstN = 1;
    tick();
    testBlocks();
    testKeyRegs();
    testProgress();
    testErrors();
    testHandshake();
    testSimultaneous();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule